// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block holds a 64-bit compare value for the supervisor-level timer and produces the supervisor timer-pending bit. It compares that value with a free-running 64-bit time input that is supplied from outside. The pending bit is level-sensitive: it is set while the unsigned time is at or beyond the compare value. It drops only once the compare value has moved past the time, which normally happens when software writes a later deadline. The pending result passes through one register, so a new compare value or a new time shows up on the pending outputs one cycle later.

Software reaches the compare value through a CSR read/write port. In wide (64-bit) operation, one address carries the whole value. In narrow (32-bit) operation, the value is split into a low half and a high half at two addresses, and writing one half leaves the other half as it was. A machine-level enable input chooses where the pending bit comes from. With the enable set, the pending bit comes from the comparison. With it clear, the pending bit follows a software-written legacy pending input instead. A build parameter marks whether the compare facility exists at all. When it does not, the enable reads as zero.

The same pending value drives two outputs: the machine pending view and the supervisor pending view. Privilege checks, interrupt delegation and priority, and the time counter itself belong to other blocks.

Top module: `sup_timer_compare`

## Requirements
- R1: While `rstN` is low, the compare value is forced to all ones and both pending outputs are 0. A read of address 0x14D returns all ones in wide mode.
- R2: With the effective enable set, both pending outputs at clock edge n+1 equal (timeIn ≥ compare) as sampled at edge n, using an unsigned 64-bit comparison. Equality counts as pending.
- R3: Pending is a level. It stays at 1 for as long as time ≥ compare. It returns to 0 one cycle after a written compare value exceeds the time.
- R4: In narrow mode (`halfMode`=1), a write to 0x14D loads compare bits 31:0 from `csrWdata[31:0]`, and a write to 0x15D loads bits 63:32 from `csrWdata[31:0]`. Each write leaves the other half unchanged.
- R5: In wide mode (`halfMode`=0), a write to 0x14D loads all 64 bits from `csrWdata`. A write to 0x15D changes nothing, and a read of 0x15D returns 0.
- R6: Readback is combinational. Wide mode at 0x14D returns the full compare value. Narrow mode returns the selected half in bits 31:0, with bits 63:32 at zero.
- R7: With the effective enable clear, the pending outputs at edge n+1 equal `swTimerPend` sampled at edge n, whatever the compare result. Compare writes still take effect.
- R8: With the effective enable set, `swTimerPend` has no effect on the pending outputs.
- R9: When the parameter `CMP_IMPL` is 0, the effective enable is held at 0 whatever `envCmpEnable` is, so pending always follows `swTimerPend`.
- R10: `mTimerPend` and `sTimerPend` are equal in every cycle.
- R11: A write to any address other than 0x14D, or other than 0x15D in narrow mode, leaves the compare value unchanged. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfMode | input | 1 | 1 selects narrow 32-bit CSR access, 0 selects wide 64-bit access |
| csrWe | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 64 | CSR write data; only bits 31:0 are used in narrow mode |
| csrRdata | output | 64 | CSR read data for `csrAddr`, combinational |
| timeIn | input | 64 | Current time value |
| envCmpEnable | input | 1 | Machine environment-config enable for the compare facility |
| swTimerPend | input | 1 | Legacy software-written pending bit |
| mTimerPend | output | 1 | Timer pending as seen in the machine pending register |
| sTimerPend | output | 1 | Timer pending as seen in the supervisor pending register |

## Verification
The hardest situation to reach from the ports is the window around a deadline. Here the time sits exactly at the compare value or one below it, and the compare value is rewritten while pending is still asserted, so the old value must show for one more cycle before the new one takes hold. Random time values almost never land there. The stimulus therefore builds most times as the model's current compare value plus a small signed offset, and it often writes compare values close to the current time. This crosses the equality boundary in both directions many times. Narrow half-writes that briefly leave a mixed old/new compare value are interleaved with these writes, and directed steps pin the all-ones boundary and the switchover between the enabled and legacy sources.

// File: rtl/stcmp_pkg.sv
package stcmp_pkg;

  localparam int TIME_W     = 64;
  localparam int HALF_W     = 32;
  localparam int NUM_HALVES = TIME_W / HALF_W;
  localparam int ADDR_W     = 12;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_FULL,
    RD_LOW,
    RD_HIGH
  } rd_sel_e;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic [NUM_HALVES-1:0] wrHalf;     // write enable per 32-bit half
    logic                  narrowData; // halves take data from wdata[HALF_W-1:0]
    rd_sel_e               rdSel;      // readback source
    logic                  useCmp;     // pending comes from the comparison
  } ctl_strobe_t;

endpackage

// File: rtl/stcmp_ctrl.sv
module stcmp_ctrl
  import stcmp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_LO  = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 12'h15D,
  parameter bit                CMP_IMPL = 1'b1
) (
  input  logic              halfMode,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              envCmpEnable,
  output ctl_strobe_t       strobes
);

  logic hitLow;
  logic hitHigh;
  logic effEnable;

  // Address decode: the high address exists only in narrow mode.
  always_comb begin
    hitLow  = (csrAddr == ADDR_LO);
    hitHigh = halfMode && (csrAddr == ADDR_HI);
  end

  // The enable is hard-wired to zero when the facility is not built.
  generate
    if (CMP_IMPL) begin : g_impl
      assign effEnable = envCmpEnable;
    end else begin : g_noimpl
      logic unusedEnable;
      assign unusedEnable = envCmpEnable;
      assign effEnable    = 1'b0;
    end
  endgenerate

  // Half write strobes: half 0 is the low word, the last half the high word.
  generate
    for (genvar k = 0; k < NUM_HALVES; k++) begin : g_wr
      if (k == 0) begin : g_low
        assign strobes.wrHalf[k] = csrWe && hitLow;
      end else begin : g_upper
        assign strobes.wrHalf[k] = csrWe && (halfMode ? hitHigh : hitLow);
      end
    end
  endgenerate

  assign strobes.narrowData = halfMode;
  assign strobes.useCmp     = effEnable;

  always_comb begin
    if (hitLow) begin
      strobes.rdSel = halfMode ? RD_LOW : RD_FULL;
    end else if (hitHigh) begin
      strobes.rdSel = RD_HIGH;
    end else begin
      strobes.rdSel = RD_NONE;
    end
  end

endmodule

// File: rtl/stcmp_datapath.sv
module stcmp_datapath
  import stcmp_pkg::*;
#(
  parameter logic [TIME_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobes,
  input  logic [TIME_W-1:0] csrWdata,
  input  logic [TIME_W-1:0] timeIn,
  input  logic              swTimerPend,
  output logic [TIME_W-1:0] cmpValue,
  output logic [TIME_W-1:0] csrRdata,
  output logic              pendQ
);

  localparam int HI_LSB = (NUM_HALVES - 1) * HALF_W;

  // One register per half, each with its own write strobe.
  generate
    for (genvar k = 0; k < NUM_HALVES; k++) begin : g_half
      logic [HALF_W-1:0] halfQ;
      logic [HALF_W-1:0] halfD;

      assign halfD = strobes.narrowData ? csrWdata[HALF_W-1:0]
                                        : csrWdata[k*HALF_W +: HALF_W];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          halfQ <= RESET_VAL[k*HALF_W +: HALF_W];
        end else if (strobes.wrHalf[k]) begin
          halfQ <= halfD;
        end
      end

      assign cmpValue[k*HALF_W +: HALF_W] = halfQ;
    end
  endgenerate

  // Unsigned level compare, then a source mux, registered once.
  logic reached;
  logic pendD;

  always_comb begin
    reached = (timeIn >= cmpValue);
    pendD   = strobes.useCmp ? reached : swTimerPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else begin
      pendQ <= pendD;
    end
  end

  // Readback mux.
  always_comb begin
    csrRdata = '0;
    unique case (strobes.rdSel)
      RD_FULL: csrRdata = cmpValue;
      RD_LOW:  csrRdata[HALF_W-1:0] = cmpValue[HALF_W-1:0];
      RD_HIGH: csrRdata[HALF_W-1:0] = cmpValue[HI_LSB +: HALF_W];
      default: csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/sup_timer_compare.sv
module sup_timer_compare
  import stcmp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_LO   = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 12'h15D,
  parameter bit                CMP_IMPL  = 1'b1,
  parameter logic [TIME_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfMode,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [TIME_W-1:0] csrWdata,
  output logic [TIME_W-1:0] csrRdata,
  input  logic [TIME_W-1:0] timeIn,
  input  logic              envCmpEnable,
  input  logic              swTimerPend,
  output logic              mTimerPend,
  output logic              sTimerPend
);

  ctl_strobe_t       strobes;
  logic [TIME_W-1:0] cmpValue;
  logic              pendQ;

  stcmp_ctrl #(
    .ADDR_LO (ADDR_LO),
    .ADDR_HI (ADDR_HI),
    .CMP_IMPL(CMP_IMPL)
  ) ctrl_i (
    .halfMode    (halfMode),
    .csrWe       (csrWe),
    .csrAddr     (csrAddr),
    .envCmpEnable(envCmpEnable),
    .strobes     (strobes)
  );

  stcmp_datapath #(
    .RESET_VAL(RESET_VAL)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .csrWdata   (csrWdata),
    .timeIn     (timeIn),
    .swTimerPend(swTimerPend),
    .cmpValue   (cmpValue),
    .csrRdata   (csrRdata),
    .pendQ      (pendQ)
  );

  // Both pending views share one source.
  assign mTimerPend = pendQ;
  assign sTimerPend = pendQ;

endmodule

// File: rtl/sup_timer_compare_chk.sv
module sup_timer_compare_chk
  import stcmp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_LO   = 12'h14D,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 12'h15D,
  parameter bit                CMP_IMPL  = 1'b1,
  parameter logic [TIME_W-1:0] RESET_VAL = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              halfMode,
  input logic              csrWe,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [TIME_W-1:0] timeIn,
  input logic              envCmpEnable,
  input logic              swTimerPend,
  input logic              mTimerPend,
  input logic              sTimerPend,
  input logic [TIME_W-1:0] cmpValue
);

  localparam int HI_LSB = (NUM_HALVES - 1) * HALF_W;

  logic effEnable;
  assign effEnable = CMP_IMPL && envCmpEnable;

  // R1: reset forces the compare value and clears pending
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (cmpValue == RESET_VAL) && !mTimerPend);

  // R2: enabled pending tracks the registered unsigned compare
  a_r2_cmp_pend: assert property (@(posedge clk) disable iff (!rstN)
    effEnable |=> mTimerPend == ($past(timeIn) >= $past(cmpValue)));

  // R7: with the facility off, pending follows the software bit
  a_r7_legacy_pend: assert property (@(posedge clk) disable iff (!rstN)
    !effEnable |=> mTimerPend == $past(swTimerPend));

  // R4: a low-half write keeps the high half
  a_r4_low_keeps_high: assert property (@(posedge clk) disable iff (!rstN)
    (halfMode && csrWe && csrAddr == ADDR_LO) |=> $stable(cmpValue[HI_LSB +: HALF_W]));

  // R4: a high-half write keeps the low half
  a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
    (halfMode && csrWe && csrAddr == ADDR_HI) |=> $stable(cmpValue[HALF_W-1:0]));

  // R5: the high address is absent in wide mode
  a_r5_wide_high_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!halfMode && csrWe && csrAddr == ADDR_HI) |=> $stable(cmpValue));

  // R11: writes to unrelated addresses change nothing
  a_r11_other_addr: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr != ADDR_LO && csrAddr != ADDR_HI) |=> $stable(cmpValue));

  // R10: the two pending views agree
  a_r10_views_equal: assert property (@(posedge clk) disable iff (!rstN)
    mTimerPend == sTimerPend);

endmodule

bind sup_timer_compare sup_timer_compare_chk #(
  .ADDR_LO  (ADDR_LO),
  .ADDR_HI  (ADDR_HI),
  .CMP_IMPL (CMP_IMPL),
  .RESET_VAL(RESET_VAL)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .halfMode    (halfMode),
  .csrWe       (csrWe),
  .csrAddr     (csrAddr),
  .timeIn      (timeIn),
  .envCmpEnable(envCmpEnable),
  .swTimerPend (swTimerPend),
  .mTimerPend  (mTimerPend),
  .sTimerPend  (sTimerPend),
  .cmpValue    (cmpValue)
);

// File: tb/sup_timer_compare_tb_top.sv
module sup_timer_compare_tb_top;

  localparam int          CLK_PERIOD  = 10;
  localparam int          RAND_STEPS  = 3000;
  localparam int          WATCHDOG    = 200000;
  localparam logic [11:0] A_LO        = 12'h14D;
  localparam logic [11:0] A_HI        = 12'h15D;
  localparam logic [11:0] A_OTHER     = 12'h14E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halfMode = 1'b0;
  logic        csrWe = 1'b0;
  logic [11:0] csrAddr = A_LO;
  logic [63:0] csrWdata = '0;
  logic [63:0] timeIn = '0;
  logic        envCmpEnable = 1'b1;
  logic        swTimerPend = 1'b0;
  logic [63:0] csrRdata;
  logic        mTimerPend;
  logic        sTimerPend;
  logic [63:0] niRdata;
  logic        niMPend;
  logic        niSPend;

  int vecCount = 0;
  int missCount = 0;
  logic [63:0] mdlCmp = '1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_timer_compare dut_i (
    .clk(clk), .rstN(rstN), .halfMode(halfMode), .csrWe(csrWe),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .timeIn(timeIn), .envCmpEnable(envCmpEnable), .swTimerPend(swTimerPend),
    .mTimerPend(mTimerPend), .sTimerPend(sTimerPend)
  );

  // Variant without the compare facility (R9).
  sup_timer_compare #(.CMP_IMPL(1'b0)) dut_noimpl_i (
    .clk(clk), .rstN(rstN), .halfMode(halfMode), .csrWe(csrWe),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(niRdata),
    .timeIn(timeIn), .envCmpEnable(envCmpEnable), .swTimerPend(swTimerPend),
    .mTimerPend(niMPend), .sTimerPend(niSPend)
  );

  function automatic logic [63:0] expRead(logic [63:0] cmp, logic [11:0] addr, logic half);
    if (addr == A_LO) return half ? {32'h0, cmp[31:0]} : cmp;
    if (half && addr == A_HI) return {32'h0, cmp[63:32]};
    return 64'h0;
  endfunction

  function automatic logic [63:0] nextCmp(logic [63:0] cmp, logic we, logic [11:0] addr,
                                          logic half, logic [63:0] wd);
    logic [63:0] r = cmp;
    if (we) begin
      if (half) begin
        if (addr == A_LO) r[31:0] = wd[31:0];
        else if (addr == A_HI) r[63:32] = wd[31:0];
      end else if (addr == A_LO) begin
        r = wd;
      end
    end
    return r;
  endfunction

  task automatic checkVal(string req, logic [63:0] act, logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at the negedge, check readback, pass the edge, check pending.
  task automatic step(string req, logic we, logic [11:0] addr, logic [63:0] wd,
                      logic [63:0] tm, logic en, logic sw, logic half);
    logic expPend;
    logic expNi;
    csrWe = we; csrAddr = addr; csrWdata = wd; timeIn = tm;
    envCmpEnable = en; swTimerPend = sw; halfMode = half;
    #1;
    checkVal({req, " readback"}, csrRdata, expRead(mdlCmp, addr, half));
    expPend = en ? (tm >= mdlCmp) : sw;
    expNi   = sw;
    @(posedge clk);
    mdlCmp = nextCmp(mdlCmp, we, addr, half, wd);
    @(negedge clk);
    checkVal({req, " mPend"}, {63'h0, mTimerPend}, {63'h0, expPend});
    checkVal("R10 views", {63'h0, sTimerPend}, {63'h0, mTimerPend});
    checkVal("R9 noimpl pend", {63'h0, niMPend}, {63'h0, expNi});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    void'($urandom(32'd2718));
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    checkVal("R1 reset readback", csrRdata, 64'hFFFF_FFFF_FFFF_FFFF);
    checkVal("R1 reset pend", {63'h0, mTimerPend}, 64'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R2: reset compare leaves a small time not pending
    step("R1", 0, A_LO, 0, 64'd100, 1, 0, 0);
    // R2: write 100 at time 100; old compare still used this edge
    step("R2", 1, A_LO, 64'd100, 64'd100, 1, 0, 0);
    step("R2 equal", 0, A_LO, 0, 64'd100, 1, 0, 0);
    step("R2 below", 0, A_LO, 0, 64'd99, 1, 0, 0);
    // R3: level holds, cleared one cycle after a larger write
    step("R3 hold", 0, A_LO, 0, 64'd200, 1, 0, 0);
    step("R3 hold", 1, A_LO, 64'd300, 64'd200, 1, 0, 0);
    step("R3 clear", 0, A_LO, 0, 64'd200, 1, 0, 0);
    // R5: high address absent in wide mode
    step("R5 wide hi", 1, A_HI, 64'h0, 64'd0, 1, 0, 0);
    step("R5 read", 0, A_LO, 0, 64'd0, 1, 0, 0);
    // R4: narrow half writes keep the other half
    step("R4 lo", 1, A_LO, 64'hDEAD_BEEF_AAAA_5555, 64'd0, 1, 0, 1);
    step("R4 rd hi", 0, A_HI, 0, 64'd0, 1, 0, 1);
    step("R4 hi", 1, A_HI, 64'h1234_5678_0000_0001, 64'd0, 1, 0, 1);
    step("R4 rd lo", 0, A_LO, 0, 64'd0, 1, 0, 1);
    step("R6 rd full", 0, A_LO, 0, 64'h1_AAAA_5555, 1, 0, 0);
    // R11: unrelated address
    step("R11 other", 1, A_OTHER, 64'h0, 64'd0, 1, 0, 0);
    step("R11 read", 0, A_OTHER, 0, 64'd0, 1, 0, 0);
    // R7: legacy source
    step("R7 sw1", 0, A_LO, 0, 64'd0, 0, 1, 0);
    step("R7 sw0", 0, A_LO, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    step("R7 wr", 1, A_LO, 64'd50, 64'd0, 0, 0, 0);
    // R8: software bit ignored when enabled
    step("R8 sw ignored", 0, A_LO, 0, 64'd10, 1, 1, 0);
    step("R8 sw ignored", 0, A_LO, 0, 64'd10, 1, 1, 0);
    // R2: all-ones boundary
    step("R2 max", 1, A_LO, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    step("R2 max", 0, A_LO, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    step("R2 max-1", 0, A_LO, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 0);

    // Random stimulus concentrated near the deadline
    for (int i = 0; i < RAND_STEPS; i++) begin
      logic        we   = ($urandom_range(3) == 0);
      logic        half = $urandom_range(1);
      logic        en   = ($urandom_range(7) != 0);
      logic        sw   = $urandom_range(1);
      logic [11:0] addr;
      logic [63:0] wd;
      int          sel  = $urandom_range(9);
      addr = (sel < 6) ? A_LO : ((sel < 9) ? A_HI : A_OTHER);
      if ($urandom_range(3) == 0) t = {$urandom, $urandom};
      else t = mdlCmp + 64'($signed($urandom_range(6)) - 3);
      wd = ($urandom_range(1) == 1) ? {$urandom, $urandom}
                                    : t + 64'($signed($urandom_range(4)) - 2);
      if (half && addr == A_HI) wd = {32'h0, t[63:32]};
      step("R2 rand", we, addr, wd, t, en, sw, half);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule